// File: doc/BRIEF.md
# Prescaled Multi-Channel PWM Bank

This block holds a set of independent pulse-width-modulation outputs. Each output has its own 32-bit configuration word in a small memory-mapped register space. One flag in the word turns the channel on. An 8-bit field sets how many ticks of each period the output is high. A 13-bit field sets how much the channel's tick is slowed relative to the block clock.

Each running channel has a prescale counter that produces one tick every N+1 clock cycles, where N is the prescale field. An 8-bit phase counter advances on each tick, so one period always lasts 256 ticks. The output is high while the phase is below the duty field.

Software writes a word and can read it back on the same address lines. A write made while a channel is running is held back until the phase counter wraps. Waveforms therefore change only at period boundaries.

Top module: `pwm_bank`

## Requirements
- R1: Channel c has its word at byte address c*16, so the channel index is taken from address bits 4 and up. A write is ignored and a read returns zero when address bits 3:0 are nonzero or when the index is NUM_CH or greater.
- R2: A read returns the last word written to that channel. Reserved bits 30:24 and 15:13 read as zero. After reset every word reads zero.
- R3: While bit 31 (enable) of a channel's word is 0, that channel's output is 0. Writing all zeros turns the channel off, and its output is 0 from the cycle after the write edge.
- R4: While running, the output is high exactly when the 8-bit phase is less than the duty field (bits 23:16). Duty 0 never goes high, and duty 255 is high for 255 of every 256 ticks.
- R5: The prescale field (bits 12:0) makes each tick last N+1 clock cycles. A period is 256*(N+1) cycles, with duty*(N+1) of them high, and the pattern repeats from phase 0.
- R6: A write that sets enable on a stopped channel starts a fresh period. The output stays 0 in the cycle after the write edge, and phase 0 begins one cycle later.
- R7: Clearing enable returns the channel's prescale and phase counters to 0.
- R8: Duty and prescale values written while the channel stays enabled take effect at the next phase wrap (255 to 0). A write that lands on the wrap edge itself takes effect at the wrap after that.
- R9: Channels are independent. Traffic to one channel never changes another channel's output or stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Byte address for both write and read |
| wr_en_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data_i | input | 32 | Word to write |
| rd_data_o | output | 32 | Word stored at addr_i (combinational) |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
A software update and a period boundary can fall in the same cycle. The wrap edge must then load the value held before the write, and the new word takes over one period later. The bench provokes this by timing a duty write so that its strobe is sampled at the very edge where the phase goes from 255 to 0. It then compares two full periods, sample by sample, against the old duty followed by the new one. A second run writes new duty and prescale values mid-period. It checks that the old waveform finishes unchanged and that the next period follows the new tick length.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int WORD_W    = 32;
  localparam int EN_BIT    = 31;
  localparam int DUTY_LSB  = 16;
  localparam int DUTY_W    = 8;
  localparam int SCALE_LSB = 0;
  localparam int SCALE_W   = 13;
  localparam int PHASE_W   = DUTY_W;

  typedef struct packed {
    logic               en;
    logic [DUTY_W-1:0]  duty;
    logic [SCALE_W-1:0] scale;
  } chan_cfg_t;

  function automatic chan_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    chan_cfg_t c;
    c.en    = w[EN_BIT];
    c.duty  = w[DUTY_LSB +: DUTY_W];
    c.scale = w[SCALE_LSB +: SCALE_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input chan_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[EN_BIT]                = c.en;
    w[DUTY_LSB +: DUTY_W]    = c.duty;
    w[SCALE_LSB +: SCALE_W]  = c.scale;
    return w;
  endfunction
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output chan_cfg_t         cfg_o [NUM_CH]
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] idx;
  logic             hit;
  chan_cfg_t        wr_cfg;
  logic             unused_rsvd;

  assign idx         = addr_i[ADDR_W-1:4];
  assign hit         = (addr_i[3:0] == 4'd0) && (32'(idx) < NUM_CH);
  assign wr_cfg      = word_to_cfg(wr_data_i);
  assign unused_rsvd = ^{wr_data_i[30:24], wr_data_i[15:13]};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_word
    logic      wr_sel;
    chan_cfg_t cfg_q;

    assign wr_sel = wr_en_i && hit && (32'(idx) == g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cfg_q <= '0;
      else if (wr_sel)  cfg_q <= wr_cfg;
    end

    assign cfg_o[g] = cfg_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit && (32'(idx) == i)) rd_data_o = cfg_to_word(cfg_o[i]);
    end
  end
endmodule

// File: rtl/pwm_bank_prescale.sv
module pwm_bank_prescale #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_limit;

  assign at_limit = (cnt_q == limit_i);
  assign tick_o   = !clr_i && at_limit;

  always_comb begin
    if (clr_i || at_limit) cnt_d = '0;
    else                   cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  chan_cfg_t          cfg_i,
  output logic               pwm_o,
  output logic               run_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [DUTY_W-1:0]  duty_o
);
  logic               run_q, run_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [DUTY_W-1:0]  duty_q, duty_d;
  logic [SCALE_W-1:0] scale_q, scale_d;
  logic               start, going, tick, wrap, load;

  assign start = cfg_i.en && !run_q;
  assign going = cfg_i.en && run_q;
  assign wrap  = tick && (phase_q == '1);
  assign load  = start || wrap;

  pwm_bank_prescale #(.CNT_W(SCALE_W)) presc_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!going),
    .limit_i (scale_q),
    .tick_o  (tick)
  );

  always_comb begin
    run_d = cfg_i.en;
    if (!going)    phase_d = '0;
    else if (tick) phase_d = phase_q + PHASE_W'(1);
    else           phase_d = phase_q;
    duty_d  = load ? cfg_i.duty  : duty_q;
    scale_d = load ? cfg_i.scale : scale_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      phase_q <= '0;
      duty_q  <= '0;
      scale_q <= '0;
    end else begin
      run_q   <= run_d;
      phase_q <= phase_d;
      duty_q  <= duty_d;
      scale_q <= scale_d;
    end
  end

  assign pwm_o   = going && (phase_q < duty_q);
  assign run_o   = run_q;
  assign phase_o = phase_q;
  assign duty_o  = duty_q;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  chan_cfg_t                       cfg [NUM_CH];
  logic [NUM_CH-1:0]               en_w;
  logic [NUM_CH-1:0]               run_w;
  logic [NUM_CH-1:0][PHASE_W-1:0]  phase_w;
  logic [NUM_CH-1:0][DUTY_W-1:0]   duty_w;

  pwm_bank_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .cfg_o     (cfg)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign en_w[g] = cfg[g].en;
    pwm_bank_chan chan_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_int),
      .cfg_i   (cfg[g]),
      .pwm_o   (pwm_o[g]),
      .run_o   (run_w[g]),
      .phase_o (phase_w[g]),
      .duty_o  (duty_w[g])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 4
) (
  input logic                   clk_i,
  input logic                   rst_n_int,
  input logic [31:0]            rd_data_o,
  input logic [NUM_CH-1:0]      pwm_o,
  input logic [NUM_CH-1:0]      en_w,
  input logic [NUM_CH-1:0]      run_w,
  input logic [NUM_CH-1:0][7:0] phase_w,
  input logic [NUM_CH-1:0][7:0] duty_w
);
  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (rd_data_o & 32'h7F00_E000) == 32'd0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
    assert_off_low_R3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
      !en_w[g] |-> !pwm_o[g]);

    assert_duty_zero_low_R4: assert property (@(posedge clk_i) disable iff (!rst_n_int)
      (duty_w[g] == 8'd0) |-> !pwm_o[g]);

    assert_phase_step_R5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
      (en_w[g] && run_w[g]) |=>
        (phase_w[g] == $past(phase_w[g]) || phase_w[g] == 8'($past(phase_w[g]) + 8'd1)));

    assert_fresh_start_R6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
      (en_w[g] && !run_w[g]) |=> (run_w[g] && phase_w[g] == 8'd0));

    assert_clear_phase_R7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
      !en_w[g] |=> (!run_w[g] && phase_w[g] == 8'd0));

    assert_duty_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
      (en_w[g] && run_w[g] && phase_w[g] != 8'hFF) |=> $stable(duty_w[g]));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk_i     (clk_i),
  .rst_n_int (rst_n_int),
  .rd_data_o (rd_data_o),
  .pwm_o     (pwm_o),
  .en_w      (en_w),
  .run_w     (run_w),
  .phase_w   (phase_w),
  .duty_w    (duty_w)
);

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     addr = '0;
  logic           we = 1'b0;
  logic [31:0]    wdat = '0;
  logic [31:0]    rdat;
  logic [NCH-1:0] pwm;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pwm_bank #(.NUM_CH(NCH), .ADDR_W(8)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .wr_en_i   (we),
    .wr_data_i (wdat),
    .rd_data_o (rdat),
    .pwm_o     (pwm)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdat = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a; we = 1'b0;
    #2;
    chk(rdat == exp, req, "readback", rdat, exp);
  endtask

  function automatic logic [31:0] word(input int d, input int s);
    return 32'h8000_0000 | (32'(d) << 16) | 32'(s);
  endfunction

  // Run one full period on channel ch with duty d, prescale s
  task automatic measure(input int ch, input int d, input int s);
    int per, mism, high, oth;
    logic [NCH-1:0] mask;
    per = 256 * (s + 1);
    mism = 0; high = 0; oth = 0;
    mask = ~(NCH'(1) << ch);
    wr(8'(ch << 4), 32'd0);
    wr(8'(ch << 4), word(d, s));
    chk(pwm[ch] == 1'b0, "R6", "output before first period", pwm[ch], 0);
    for (int k = 0; k < per; k++) begin
      @(negedge clk);
      if (pwm[ch] != ((k / (s + 1)) < d)) mism++;
      if (pwm[ch]) high++;
      if ((pwm & mask) != '0) oth++;
    end
    chk(mism == 0, "R4", $sformatf("pattern mismatches ch%0d d%0d s%0d", ch, d, s), mism, 0);
    chk(high == d * (s + 1), "R5", $sformatf("high cycles ch%0d d%0d s%0d", ch, d, s), high, d * (s + 1));
    chk(oth == 0, "R9", "idle channels stayed low", oth, 0);
    @(negedge clk);
    chk(pwm[ch] == (d > 0), "R5", "next period restarts at phase 0", pwm[ch], (d > 0));
    wr(8'(ch << 4), 32'd0);
    chk(pwm[ch] == 1'b0, "R3", "zero word turns output off", pwm[ch], 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int duties [8] = '{0, 1, 2, 127, 128, 200, 254, 255};
    int scales [3] = '{0, 1, 3};
    int mism;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(pwm == '0, "R3", "outputs after reset", pwm, 0);
    for (int c = 0; c < NCH; c++) rd_chk(8'(c << 4), 32'd0, "R2");

    // R2 readback and reserved bits
    wr(8'h20, 32'hFFFF_FFFF);
    rd_chk(8'h20, 32'h80FF_1FFF, "R2");
    wr(8'h20, 32'd0);
    rd_chk(8'h20, 32'd0, "R2");
    wr(8'h10, 32'h7F00_E000);
    rd_chk(8'h10, 32'd0, "R2");
    chk(pwm[1] == 1'b0, "R3", "reserved-only word leaves output low", pwm[1], 0);

    // R1 decode: misaligned and out-of-range addresses
    wr(8'h04, word(255, 0));
    rd_chk(8'h00, 32'd0, "R1");
    rd_chk(8'h04, 32'd0, "R1");
    wr(8'h40, word(255, 0));
    rd_chk(8'h40, 32'd0, "R1");
    repeat (4) @(negedge clk);
    chk(pwm == '0, "R1", "ignored writes drive no output", pwm, 0);

    // R9 writes to one channel leave another's word alone
    wr(8'h30, word(10, 7));
    wr(8'h00, word(20, 3));
    rd_chk(8'h30, word(10, 7), "R9");
    wr(8'h30, 32'd0);
    wr(8'h00, 32'd0);

    // sweep of duty and prescale over all channels (R4 R5 R6 R7)
    for (int di = 0; di < 8; di++)
      for (int si = 0; si < 3; si++)
        measure((di + si) % NCH, duties[di], scales[si]);

    // R8 mid-period update of duty and prescale
    wr(8'h10, word(64, 0));
    mism = 0;
    for (int k = 0; k < 256 + 512; k++) begin
      @(negedge clk);
      if (k < 256) begin
        if (pwm[1] != (k < 64)) mism++;
      end else begin
        if (pwm[1] != (((k - 256) / 2) < 192)) mism++;
      end
      if (k == 10) begin addr = 8'h10; wdat = word(192, 1); we = 1'b1; end
      if (k == 11) we = 1'b0;
    end
    chk(mism == 0, "R8", "mid-period update deferred to wrap", mism, 0);
    wr(8'h10, 32'd0);

    // R8 write landing on the wrap edge itself
    wr(8'h20, word(100, 0));
    mism = 0;
    for (int k = 0; k < 768; k++) begin
      @(negedge clk);
      if (k < 512) begin
        if (pwm[2] != ((k % 256) < 100)) mism++;
      end else begin
        if (pwm[2] != ((k % 256) < 30)) mism++;
      end
      if (k == 255) begin addr = 8'h20; wdat = word(30, 0); we = 1'b1; end
      if (k == 256) we = 1'b0;
    end
    chk(mism == 0, "R8", "write on wrap edge applies one period later", mism, 0);
    rd_chk(8'h20, word(30, 0), "R2");

    // R7 disable mid-period then re-enable starts from phase 0
    repeat (37) @(negedge clk);
    wr(8'h20, 32'd0);
    chk(pwm[2] == 1'b0, "R3", "disable mid-period", pwm[2], 0);
    wr(8'h20, word(3, 2));
    mism = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (pwm[2] != ((k / 3) < 3)) mism++;
    end
    chk(mism == 0, "R7", "re-enable restarts counters", mism, 0);
    wr(8'h20, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule